// File: doc/BRIEF.md
# Latency-Matching Stream Aligner

Two upstream datapaths share one clock, and each has a fixed pipeline latency set when the design is elaborated. The aligner takes both results and adds delay only to the faster path. That delay equals the latency difference, so a token that entered both upstream paths on the same cycle comes out of the aligner on both sides on the same cycle. Downstream logic can then combine the two buses without knowing either latency.

Each side carries a data bus and a valid flag. The flag travels through exactly the same delay as its data. A combined flag reports when both aligned sides hold valid data in the same cycle. The depths are worked out from the two latency parameters during elaboration. A side that needs no extra delay is built as a plain wire with no registers, so the three cases (A slower, B slower, equal) need no source change. The block has no handshake or backpressure.

Top module: `lat_align_unit`

## Requirements
- R1: Side A is delayed by max(0, LAT_B - LAT_A) cycles and side B by max(0, LAT_A - LAT_B) cycles. A value driven on a delayed input in cycle c appears on that side's output in cycle c + delay.
- R2: A token entering both upstream paths in the same cycle leaves the aligner on both sides in the same cycle, which is cycle max(LAT_A, LAT_B) after it entered. The tag on side A equals the tag on side B, where side B carries the bitwise inverse.
- R3: When LAT_A equals LAT_B, both sides pass straight through in the same cycle with no added delay.
- R4: A side whose computed depth is zero or negative is purely combinational. Its outputs follow its inputs within the same cycle.
- R5: Each valid flag goes through the same delay as its data. A delayed side never presents a valid that was not driven exactly one delay earlier.
- R6: `pair_valid` is high exactly when `a_valid_out` and `b_valid_out` are both high.
- R7: When `rst_n` is low at a rising edge (synchronous, active-low), every delayed valid stage is cleared. Data stages keep their contents. Tokens that were in flight at that edge never appear at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock of both datapaths |
| rst_n | input | 1 | Synchronous active-low reset of valid stages |
| a_data | input | DATA_W | Result bus of datapath A |
| a_valid | input | 1 | Valid flag of datapath A |
| b_data | input | DATA_W | Result bus of datapath B |
| b_valid | input | 1 | Valid flag of datapath B |
| a_data_out | output | DATA_W | Side A data, aligned |
| a_valid_out | output | 1 | Side A valid, aligned |
| b_data_out | output | DATA_W | Side B data, aligned |
| b_valid_out | output | 1 | Side B valid, aligned |
| pair_valid | output | 1 | Both aligned sides valid |

## Verification
Three instances are driven with the same tagged token stream, with latency pairs (5,2), (1,4) and (3,3). These pairs separate delay placed on side B, delay placed on side A, and no delay on either side. Each token's valid bits on the two sides come from a table that mixes A-only, B-only, both-valid and idle cycles. This shows whether the flags follow their own data rather than each other, and whether the combined flag is a true AND. A reset pulse in the middle of a dense burst shows whether in-flight tokens are dropped on the delayed side while the wire side keeps following its input.

// File: rtl/lat_align_pkg.sv
// Package: shared constants and the elaboration-time depth calculation for
// the latency-matching aligner. Assumes latencies are non-negative integers.
package lat_align_pkg;

    // Upper bound on a supported upstream latency.
    localparam int MAX_LATENCY = 32;

    // Depth of extra delay this side needs so it lines up with the other.
    function automatic int pad_depth(input int own_lat, input int other_lat);
        return (other_lat > own_lat) ? (other_lat - own_lat) : 0;
    endfunction

    // Larger of the two latencies: total cycles seen by an aligned token.
    function automatic int aligned_latency(input int lat_x, input int lat_y);
        return (lat_x > lat_y) ? lat_x : lat_y;
    endfunction

endpackage

// File: rtl/lat_delay_line.sv
// Module: lat_delay_line
// Delays a data bus and its valid flag by DEPTH clock cycles.
// Assumes: DEPTH <= 0 means no registers at all (a wire); valid stages are
// cleared by a synchronous active-low reset, data stages are never reset.
module lat_delay_line #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] in_data,
    input  logic             in_valid,
    output logic [WIDTH-1:0] out_data,
    output logic             out_valid
);

    localparam int STAGES = (DEPTH > 0) ? DEPTH : 1;
    localparam int CNT_W  = $clog2(STAGES + 1) + 1;

    generate
        if (DEPTH <= 0) begin : g_wire
            // Zero depth: combinational pass-through.
            assign out_data  = in_data;
            assign out_valid = in_valid;
        end else begin : g_pipe
            logic [WIDTH-1:0]  dat_q [STAGES];
            logic [STAGES-1:0] vld_q;
            logic [CNT_W-1:0]  inflight_q;

            // Shift data one stage per rising edge; no reset on data.
            always_ff @(posedge clk) begin
                dat_q[0] <= in_data;
                for (int k = 1; k < STAGES; k++) begin
                    dat_q[k] <= dat_q[k-1];
                end
            end

            // Shift valid flags alongside data; cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q <= '0;
                end else begin
                    vld_q[0] <= in_valid;
                    for (int k = 1; k < STAGES; k++) begin
                        vld_q[k] <= vld_q[k-1];
                    end
                end
            end

            assign out_data  = dat_q[STAGES-1];
            assign out_valid = vld_q[STAGES-1];

            // Checker-only count of valid tokens currently inside the line.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    inflight_q <= '0;
                end else begin
                    inflight_q <= inflight_q + CNT_W'(in_valid) - CNT_W'(out_valid);
                end
            end

            // R1: first stage captures the input flag of the previous cycle.
            p_first_stage_r1: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (vld_q[0] == $past(in_valid)))
                else $error("p_first_stage_r1");

            // R7: after a reset edge no valid is left anywhere in the line.
            p_reset_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(rst_n) |-> (vld_q == '0))
                else $error("p_reset_clears_r7");

            // R5: independent token count agrees with the flags in the line.
            p_token_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (32'(inflight_q) == $countones(vld_q)))
                else $error("p_token_count_r5");

            // R5: an output valid needs a token that entered earlier.
            p_no_spurious_r5: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (inflight_q != '0))
                else $error("p_no_spurious_r5");
        end
    endgenerate

endmodule

// File: rtl/lat_pair_join.sv
// Module: lat_pair_join
// Combines the two aligned valid flags into one pair-valid flag.
// Assumes both inputs already refer to the same token cycle.
module lat_pair_join (
    input  logic side_a_vld,
    input  logic side_b_vld,
    output logic both_vld
);

    // Both sides must hold valid data in the same cycle.
    always_comb begin
        both_vld = side_a_vld & side_b_vld;
    end

endmodule

// File: rtl/lat_align_unit.sv
// Module: lat_align_unit
// Adds delay to the faster of two datapath outputs so tokens that entered
// both upstream paths together leave here in the same cycle.
// Assumes: one shared clock, fixed latencies 0..MAX_LATENCY known at
// elaboration, no handshake or backpressure.
module lat_align_unit
    import lat_align_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int LAT_A  = 5,
    parameter int LAT_B  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_valid,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_valid,
    output logic [DATA_W-1:0] a_data_out,
    output logic              a_valid_out,
    output logic [DATA_W-1:0] b_data_out,
    output logic              b_valid_out,
    output logic              pair_valid
);

    localparam int PAD_A = pad_depth(LAT_A, LAT_B);
    localparam int PAD_B = pad_depth(LAT_B, LAT_A);

    // Parameter range guard, evaluated once at start-up.
    initial begin
        if (LAT_A < 0 || LAT_B < 0 || LAT_A > MAX_LATENCY || LAT_B > MAX_LATENCY) begin
            $error("lat_align_unit: latency parameter out of range");
        end
    end

    lat_delay_line #(.WIDTH(DATA_W), .DEPTH(PAD_A)) side_a_dly_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (a_data),
        .in_valid (a_valid),
        .out_data (a_data_out),
        .out_valid(a_valid_out)
    );

    lat_delay_line #(.WIDTH(DATA_W), .DEPTH(PAD_B)) side_b_dly_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_data  (b_data),
        .in_valid (b_valid),
        .out_data (b_data_out),
        .out_valid(b_valid_out)
    );

    lat_pair_join join_i (
        .side_a_vld(a_valid_out),
        .side_b_vld(b_valid_out),
        .both_vld  (pair_valid)
    );

endmodule

// File: tb/lat_align_unit_tb.sv
// Bench: three aligners (A slower, B slower, equal) fed from one tagged
// token table; expected outputs come from the requirement formulas.
module lat_align_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int RST_CYC    = 60;
    localparam int END_CYC    = 100;
    localparam int LA_T [3]   = '{5, 1, 3};
    localparam int LB_T [3]   = '{2, 4, 3};

    // Token table: [9] valid on side A, [8] valid on side B, [7:0] tag high byte.
    localparam logic [9:0] VEC_TBL [16] = '{
        10'h3A1, 10'h3B2, 10'h2C3, 10'h1D4, 10'h000, 10'h3E5, 10'h3F6, 10'h207,
        10'h318, 10'h129, 10'h33A, 10'h000, 10'h34B, 10'h25C, 10'h36D, 10'h37E
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] ad [3];
    logic [DW-1:0] bd [3];
    logic          av [3];
    logic          bv [3];
    logic [DW-1:0] ado [3];
    logic [DW-1:0] bdo [3];
    logic          avo [3];
    logic          bvo [3];
    logic          pvo [3];

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lat_align_unit #(.DATA_W(DW), .LAT_A(LA_T[0]), .LAT_B(LB_T[0])) dut_i (
        .clk(clk), .rst_n(rst_n),
        .a_data(ad[0]), .a_valid(av[0]), .b_data(bd[0]), .b_valid(bv[0]),
        .a_data_out(ado[0]), .a_valid_out(avo[0]),
        .b_data_out(bdo[0]), .b_valid_out(bvo[0]), .pair_valid(pvo[0])
    );

    lat_align_unit #(.DATA_W(DW), .LAT_A(LA_T[1]), .LAT_B(LB_T[1])) dut_bgt_i (
        .clk(clk), .rst_n(rst_n),
        .a_data(ad[1]), .a_valid(av[1]), .b_data(bd[1]), .b_valid(bv[1]),
        .a_data_out(ado[1]), .a_valid_out(avo[1]),
        .b_data_out(bdo[1]), .b_valid_out(bvo[1]), .pair_valid(pvo[1])
    );

    lat_align_unit #(.DATA_W(DW), .LAT_A(LA_T[2]), .LAT_B(LB_T[2])) dut_eq_i (
        .clk(clk), .rst_n(rst_n),
        .a_data(ad[2]), .a_valid(av[2]), .b_data(bd[2]), .b_valid(bv[2]),
        .a_data_out(ado[2]), .a_valid_out(avo[2]),
        .b_data_out(bdo[2]), .b_valid_out(bvo[2]), .pair_valid(pvo[2])
    );

    // Token word entering upstream at cycle src: {valid, data}; side B inverted.
    function automatic logic [DW:0] token(input int src, input bit side_b);
        logic [9:0]    e;
        logic [DW-1:0] tag;
        if (src < 0) return '0;
        e   = VEC_TBL[src % 16];
        tag = {e[7:0], 8'(src)};
        return {(side_b ? e[8] : e[9]), (side_b ? ~tag : tag)};
    endfunction

    task automatic check(input string req, input string what, input logic [DW:0] got,
                         input logic [DW:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Drive all inputs for cycle c: upstream model delays each token by its latency.
    task automatic drive(input int c);
        for (int k = 0; k < 3; k++) begin
            logic [DW:0] wa;
            logic [DW:0] wb;
            wa = (c < RST_CYC) ? token(c - LA_T[k], 1'b0) : '0;
            wb = (c < RST_CYC) ? token(c - LB_T[k], 1'b1) : '0;
            av[k] = wa[DW]; ad[k] = wa[DW-1:0];
            bv[k] = wb[DW]; bd[k] = wb[DW-1:0];
        end
        rst_n = (c == RST_CYC) ? 1'b0 : 1'b1;
    endtask

    // Compare every output of instance k in cycle c with the requirement formulas.
    task automatic check_dut(input int k, input int c);
        int da;
        int db;
        int ml;
        logic [DW:0] ea;
        logic [DW:0] eb;
        bit va;
        bit vb;
        string rq;
        da = (LB_T[k] > LA_T[k]) ? LB_T[k] - LA_T[k] : 0;
        db = (LA_T[k] > LB_T[k]) ? LA_T[k] - LB_T[k] : 0;
        ml = (LA_T[k] > LB_T[k]) ? LA_T[k] : LB_T[k];
        rq = (da == 0 && db == 0) ? "R3" : "R1";
        ea = token(c - ml, 1'b0);
        eb = token(c - ml, 1'b1);
        // R7: tokens in flight at the reset edge are dropped.
        va = ea[DW] && (c < RST_CYC || (c == RST_CYC && da > 0));
        vb = eb[DW] && (c < RST_CYC || (c == RST_CYC && db > 0));
        check((c >= RST_CYC) ? "R7" : "R5", $sformatf("inst%0d a_valid c%0d", k, c),
              {16'h0, avo[k]}, {16'h0, va});
        check((c >= RST_CYC) ? "R7" : "R5", $sformatf("inst%0d b_valid c%0d", k, c),
              {16'h0, bvo[k]}, {16'h0, vb});
        if (va) check(rq, $sformatf("inst%0d a_data c%0d", k, c), {1'b0, ado[k]}, {1'b0, ea[DW-1:0]});
        if (vb) check(rq, $sformatf("inst%0d b_data c%0d", k, c), {1'b0, bdo[k]}, {1'b0, eb[DW-1:0]});
        // R2: both sides carry the same tag when both are valid.
        if (va && vb) check("R2", $sformatf("inst%0d tag pair c%0d", k, c),
                            {1'b0, ado[k]}, {1'b0, ~bdo[k]});
        check("R6", $sformatf("inst%0d pair_valid c%0d", k, c),
              {16'h0, pvo[k]}, {16'h0, (va && vb)});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        for (int k = 0; k < 3; k++) begin
            av[k] = 1'b0; bv[k] = 1'b0; ad[k] = '0; bd[k] = '0;
        end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        // R7: reset state, all flags low while reset holds.
        for (int k = 0; k < 3; k++) begin
            check("R7", $sformatf("inst%0d reset a_valid", k), {16'h0, avo[k]}, '0);
            check("R7", $sformatf("inst%0d reset b_valid", k), {16'h0, bvo[k]}, '0);
            check("R6", $sformatf("inst%0d reset pair", k), {16'h0, pvo[k]}, '0);
        end
        // Table walk, then mid-stream reset at RST_CYC and drain.
        for (int c = 0; c <= END_CYC; c++) begin
            drive(c);
            #1;
            for (int k = 0; k < 3; k++) check_dut(k, c);
            @(negedge clk);
        end
        // R4: zero-depth side of instance 0 (side A) follows input within a cycle.
        av[0] = 1'b1; ad[0] = 16'hC3C3; rst_n = 1'b1;
        #1;
        check("R4", "inst0 wire a_valid", {16'h0, avo[0]}, {16'h0, 1'b1});
        check("R4", "inst0 wire a_data", {1'b0, ado[0]}, {1'b0, 16'hC3C3});
        ad[0] = 16'h5A5A;
        #1;
        check("R4", "inst0 wire a_data change", {1'b0, ado[0]}, {1'b0, 16'h5A5A});
        finish_run();
    end

    initial begin
        #(CLK_PERIOD * 2000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule